// File: doc/BRIEF.md
# Serial Flash Write-Protection Status Unit

This block holds the status byte of a serial NOR flash and decides, command by command, whether a write-type request may proceed. An upstream command decoder presents one decoded command per cycle together with its target address and, for a status write, its data byte. The unit combines the write-enable latch, the two-level block-protection field, the protection lock and the write-protect pin to accept or refuse each request. It then reports the decision one cycle later.

Accepted program and erase requests start a self-timed busy period, modelled by a cycle countdown whose length depends on the kind of operation. The end of that period clears the write-enable latch. In auto-increment programming, a sequence of program requests walks upward from a start address. The sequence stops without wrapping once it has programmed the last address below the protected region. Status writes need a two-step arming sequence, and they are gated by a lock bit that, while the write-protect pin is low, can only be set.

Top module: `flash_wp_status_unit`

## Requirements
- R1: `status_o` carries busy at bit 0, write-enable latch at bit 1, protection level low bit at bit 2 and high bit at bit 3, auto-increment mode at bit 6 and the lock at bit 7; bits 5 and 4 always read 0.
- R2: After synchronous reset, `status_o` is 8'h0C: both level bits set, all other bits clear.
- R3: An accepted write-enable command sets bit 1; an accepted write-disable command clears bit 1 and bit 6.
- R4: For each write-type command (codes 1 to 9), exactly one of `exec_o` or `ignore_o` pulses high in the cycle after the command. A program, auto-increment program, sector erase, block erase or chip erase is refused when bit 1 is 0.
- R5: A status write is accepted only when the command right before it was an arm command. Any other command in between, including a status read, voids the arming. Only bits 7, 3 and 2 are taken from `cmd_data`.
- R6: A status write is refused while `wp_n` is 0 and the lock is 1. With `wp_n` at 0 and the lock at 0, the write may set the lock. With `wp_n` at 1, the lock and both level bits are freely writable.
- R7: Level 00 protects nothing, 01 protects addresses 18000h to 1FFFFh, 10 protects 10000h to 1FFFFh, and 11 protects everything. Program and erase requests to a protected address are refused. A sector erase is judged on address bits 16:12 with the rest cleared, and a block erase on bits 16:15. The judged address appears on `op_addr_o` after acceptance.
- R8: A chip erase is accepted only when both level bits are 0.
- R9: The first auto-increment program uses `cmd_addr`, and each later one uses the previous address plus one. When the programmed address is the top unprotected address (1FFFFh, 17FFFh or 0FFFFh for levels 00, 01 and 10), its completion clears bit 6 and bit 1. While bit 6 is set, plain program, sector, block and chip erase requests are refused.
- R10: An accepted program or erase raises busy in the next cycle. Busy then stays high for PROG_CYC cycles for both program kinds, SECT_CYC for a sector erase, BLK_CYC for a block erase and CHIP_CYC for a chip erase. Completion of a plain program or any erase clears bit 1.
- R11: While busy is 1, every write-type command is refused, and `status_o` still reports the status with bit 0 set.
- R12: Command codes on `cmd_op` are: 0 other, 1 write-enable, 2 write-disable, 3 arm status write, 4 status write, 5 program, 6 auto-increment program, 7 sector erase, 8 block erase, 9 chip erase, and 10 status read. Codes 0 and 10 pulse neither decision output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One decoded command this cycle |
| cmd_op | input | 4 | Command code (R12) |
| cmd_addr | input | ADDR_W | Target address |
| cmd_data | input | 8 | Status write data |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| exec_o | output | 1 | Write-type command accepted (pulse) |
| ignore_o | output | 1 | Write-type command refused (pulse) |
| busy_o | output | 1 | Self-timed operation in progress |
| seq_mode_o | output | 1 | Auto-increment programming active |
| op_addr_o | output | ADDR_W | Address of the last accepted program or erase |

## Verification
The hardest situation to reach is the end of an auto-increment sequence. That needs the protection level first moved through an armed status write, then a write-enable, then a start address one below the top unprotected address. After that come two complete busy periods, with a refused plain program between them while the mode is still active. The bench drives exactly that chain with level 10, so the second program lands on 0FFFFh and its completion drops both the mode and the enable. Lock behaviour is reached by lowering the write-protect pin, setting the lock with an armed write, and trying to clear it before raising the pin again.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [3:0] {
        OP_OTHER  = 4'd0,
        OP_WREN   = 4'd1,
        OP_WRDI   = 4'd2,
        OP_ARM    = 4'd3,
        OP_STWR   = 4'd4,
        OP_PROG   = 4'd5,
        OP_SEQ    = 4'd6,
        OP_SECT   = 4'd7,
        OP_BLK    = 4'd8,
        OP_CHIP   = 4'd9,
        OP_STRD   = 4'd10
    } wp_op_e;

    typedef enum logic [2:0] {
        JOB_PROG,
        JOB_SEQ,
        JOB_SECT,
        JOB_BLK,
        JOB_CHIP
    } wp_job_e;

    typedef struct packed {
        logic       lock;
        logic       seq;
        logic [1:0] spare;
        logic [1:0] lvl;
        logic       wen;
        logic       busy;
    } wp_status_t;

    localparam logic [1:0] LVL_AT_RESET = 2'b11;
    localparam logic [7:0] STWR_MASK    = 8'b1000_1100;

    function automatic logic is_write_op(wp_op_e op);
        return (op >= OP_WREN) && (op <= OP_CHIP);
    endfunction

    function automatic logic is_array_op(wp_op_e op);
        return (op >= OP_PROG) && (op <= OP_CHIP);
    endfunction

    function automatic wp_job_e job_of(wp_op_e op);
        case (op)
            OP_SEQ:  return JOB_SEQ;
            OP_SECT: return JOB_SECT;
            OP_BLK:  return JOB_BLK;
            OP_CHIP: return JOB_CHIP;
            default: return JOB_PROG;
        endcase
    endfunction

endpackage

// File: rtl/wp_prot_decode.sv
module wp_prot_decode #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        lvl,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot,
    output logic [ADDR_W-1:0] top_free
);
    localparam logic [ADDR_W-1:0] ALL_ONE  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] HALF_TOP = ALL_ONE >> 1;
    localparam logic [ADDR_W-1:0] QTR_TOP  = ALL_ONE & ~(ALL_ONE & (ADDR_W'(1) << (ADDR_W-2)));

    always_comb begin
        case (lvl)
            2'b00: begin
                prot     = 1'b0;
                top_free = ALL_ONE;
            end
            2'b01: begin
                prot     = &addr[ADDR_W-1 -: 2];
                top_free = QTR_TOP;
            end
            2'b10: begin
                prot     = addr[ADDR_W-1];
                top_free = HALF_TOP;
            end
            default: begin
                prot     = 1'b1;
                top_free = '0;
            end
        endcase
    end
endmodule

// File: rtl/wp_busy_timer.sv
module wp_busy_timer
    import flash_wp_pkg::*;
#(
    parameter int PROG_CYC = 4,
    parameter int SECT_CYC = 6,
    parameter int BLK_CYC  = 8,
    parameter int CHIP_CYC = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  wp_job_e job_in,
    output logic    busy,
    output logic    done,
    output wp_job_e job
);
    localparam int MAX_A  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_B  = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_C + 1);

    logic [CW-1:0] cnt_q;

    function automatic logic [CW-1:0] dur_of(wp_job_e j);
        case (j)
            JOB_SECT: return CW'(SECT_CYC);
            JOB_BLK:  return CW'(BLK_CYC);
            JOB_CHIP: return CW'(CHIP_CYC);
            default:  return CW'(PROG_CYC);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            job   <= JOB_PROG;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= dur_of(job_in) - CW'(1);
            job   <= job_in;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/flash_wp_status_unit.sv
module flash_wp_status_unit
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int SECT_W   = 12,
    parameter int BLK_W    = 15,
    parameter int PROG_CYC = 4,
    parameter int SECT_CYC = 6,
    parameter int BLK_CYC  = 8,
    parameter int CHIP_CYC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    output logic [7:0]        status_o,
    output logic              exec_o,
    output logic              ignore_o,
    output logic              busy_o,
    output logic              seq_mode_o,
    output logic [ADDR_W-1:0] op_addr_o
);
    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_W;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_W;

    wp_op_e            op;
    wp_status_t        stat_q;
    wp_status_t        stat_out;
    logic              arm_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] eff_addr;
    logic              prot;
    logic [ADDR_W-1:0] top_free;
    logic              grant;
    logic              busy;
    logic              done;
    wp_job_e           done_job;
    logic              start;
    logic              locked;

    assign op = wp_op_e'(cmd_op);

    always_comb begin
        case (op)
            OP_SEQ:  eff_addr = stat_q.seq ? (ptr_q + ADDR_W'(1)) : cmd_addr;
            OP_SECT: eff_addr = cmd_addr & SECT_MASK;
            OP_BLK:  eff_addr = cmd_addr & BLK_MASK;
            default: eff_addr = cmd_addr;
        endcase
    end

    wp_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
        .lvl      (stat_q.lvl),
        .addr     (eff_addr),
        .prot     (prot),
        .top_free (top_free)
    );

    assign locked = !wp_n && stat_q.lock;

    always_comb begin
        grant = 1'b0;
        if (!busy) begin
            case (op)
                OP_WREN, OP_WRDI, OP_ARM: grant = 1'b1;
                OP_STWR: grant = arm_q && !locked;
                OP_PROG, OP_SECT, OP_BLK:
                         grant = stat_q.wen && !stat_q.seq && !prot;
                OP_SEQ:  grant = stat_q.wen && !prot;
                OP_CHIP: grant = stat_q.wen && !stat_q.seq && (stat_q.lvl == 2'b00);
                default: grant = 1'b0;
            endcase
        end
    end

    assign start = cmd_valid && grant && is_array_op(op);

    wp_busy_timer #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .BLK_CYC  (BLK_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .job_in (job_of(op)),
        .busy   (busy),
        .done   (done),
        .job    (done_job)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '{lock: 1'b0, seq: 1'b0, spare: 2'b00, lvl: LVL_AT_RESET,
                           wen: 1'b0, busy: 1'b0};
            arm_q     <= 1'b0;
            ptr_q     <= '0;
            exec_o    <= 1'b0;
            ignore_o  <= 1'b0;
            op_addr_o <= '0;
        end else begin
            exec_o   <= cmd_valid && is_write_op(op) && grant;
            ignore_o <= cmd_valid && is_write_op(op) && !grant;
            if (cmd_valid) arm_q <= (op == OP_ARM) && !busy;

            if (cmd_valid && grant) begin
                case (op)
                    OP_WREN: stat_q.wen <= 1'b1;
                    OP_WRDI: begin
                        stat_q.wen <= 1'b0;
                        stat_q.seq <= 1'b0;
                    end
                    OP_STWR: stat_q <= wp_status_t'((stat_q & ~STWR_MASK) | (cmd_data & STWR_MASK));
                    OP_SEQ: begin
                        stat_q.seq <= 1'b1;
                        ptr_q      <= eff_addr;
                        op_addr_o  <= eff_addr;
                    end
                    OP_PROG, OP_SECT, OP_BLK: op_addr_o <= eff_addr;
                    default: ;
                endcase
            end

            if (done) begin
                if (done_job == JOB_SEQ) begin
                    if (ptr_q == top_free) begin
                        stat_q.seq <= 1'b0;
                        stat_q.wen <= 1'b0;
                    end
                end else begin
                    stat_q.wen <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        stat_out      = stat_q;
        stat_out.busy = busy;
    end

    assign status_o   = stat_out;
    assign busy_o     = busy;
    assign seq_mode_o = stat_q.seq;
endmodule

// File: rtl/flash_wp_status_chk.sv
module flash_wp_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       wp_n,
    input logic [7:0] status_o,
    input logic       exec_o,
    input logic       ignore_o,
    input logic       busy_o
);
    assert_spare_zero_R1: assert property (@(posedge clk) disable iff (rst)
        status_o[5:4] == 2'b00);

    assert_reset_value_R2: assert property (@(posedge clk)
        rst |=> status_o == 8'h0C);

    assert_one_decision_R4: assert property (@(posedge clk) disable iff (rst)
        !(exec_o && ignore_o));

    assert_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (cmd_op >= 4'd5) && (cmd_op <= 4'd9) && !status_o[1] |=> ignore_o);

    assert_lock_holds_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (cmd_op == 4'd4) && !wp_n && status_o[7]
        |=> status_o[7] && $stable(status_o[3:2]));

    assert_chip_level_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (cmd_op == 4'd9) && (status_o[3:2] != 2'b00) |=> !exec_o);

    assert_busy_refuses_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && busy_o |=> !exec_o);
endmodule

bind flash_wp_status_unit flash_wp_status_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wp_n      (wp_n),
    .status_o  (status_o),
    .exec_o    (exec_o),
    .ignore_o  (ignore_o),
    .busy_o    (busy_o)
);

// File: tb/flash_wp_status_unit_tb_top.sv
`timescale 1ns/1ps
module flash_wp_status_unit_tb_top;
    localparam int AW = 17;
    localparam int PC = 4, SC = 6, BC = 8, CC = 10;
    localparam int C_OTHER = 0, C_WREN = 1, C_WRDI = 2, C_ARM = 3, C_STWR = 4,
                   C_PROG = 5, C_SEQ = 6, C_SECT = 7, C_BLK = 8, C_CHIP = 9, C_STRD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          wp_n = 1'b1;
    logic [7:0]    status_o;
    logic          exec_o, ignore_o, busy_o, seq_mode_o;
    logic [AW-1:0] op_addr_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_wp_status_unit #(.ADDR_W(AW), .SECT_W(12), .BLK_W(15),
        .PROG_CYC(PC), .SECT_CYC(SC), .BLK_CYC(BC), .CHIP_CYC(CC)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
        .status_o(status_o), .exec_o(exec_o), .ignore_o(ignore_o),
        .busy_o(busy_o), .seq_mode_o(seq_mode_o), .op_addr_o(op_addr_o));

    // behavioural reference model
    int m_left = 0, m_job = 0, m_ptr = 0, m_addr = 0;
    bit m_wen = 0, m_seq = 0, m_lock = 0, m_arm = 0, m_exec = 0, m_ign = 0;
    int m_lvl = 3;
    bit model_on = 0;

    function automatic bit guarded(int lvl, int a);
        if (lvl == 0) return 0;
        if (lvl == 1) return a >= 'h18000;
        if (lvl == 2) return a >= 'h10000;
        return 1;
    endfunction

    function automatic int last_free(int lvl);
        if (lvl == 0) return 'h1FFFF;
        if (lvl == 1) return 'h17FFF;
        if (lvl == 2) return 'h0FFFF;
        return -1;
    endfunction

    always @(posedge clk) begin : model
        bit was_busy, ok, wr;
        int a, o;
        if (rst) begin
            m_left = 0; m_wen = 0; m_seq = 0; m_lock = 0; m_lvl = 3;
            m_arm = 0; m_exec = 0; m_ign = 0; m_addr = 0; m_ptr = 0;
        end else begin
            was_busy = (m_left > 0);
            m_exec = 0; m_ign = 0;
            if (cmd_valid) begin
                o = cmd_op; a = cmd_addr; ok = 0;
                wr = (o >= 1) && (o <= 9);
                if (o == C_SEQ && m_seq) a = m_ptr + 1;
                if (o == C_SECT) a = a - (a % 4096);
                if (o == C_BLK)  a = a - (a % 32768);
                if (!was_busy) begin
                    if (o == C_WREN || o == C_WRDI || o == C_ARM) ok = 1;
                    if (o == C_STWR) ok = m_arm && !(!wp_n && m_lock);
                    if (o == C_PROG || o == C_SECT || o == C_BLK) ok = m_wen && !m_seq && !guarded(m_lvl, a);
                    if (o == C_SEQ)  ok = m_wen && !guarded(m_lvl, a);
                    if (o == C_CHIP) ok = m_wen && !m_seq && (m_lvl == 0);
                end
                m_arm = (o == C_ARM) && !was_busy;
                if (ok) begin
                    if (o == C_WREN) m_wen = 1;
                    if (o == C_WRDI) begin m_wen = 0; m_seq = 0; end
                    if (o == C_STWR) begin m_lock = cmd_data[7]; m_lvl = cmd_data[3:2]; end
                    if (o >= C_PROG && o <= C_BLK) m_addr = a;
                    if (o == C_SEQ) begin m_seq = 1; m_ptr = a; end
                    if (o >= C_PROG && o <= C_CHIP) begin
                        m_job = o;
                        m_left = (o == C_SECT) ? SC : (o == C_BLK) ? BC : (o == C_CHIP) ? CC : PC;
                    end
                end
                m_exec = wr && ok;
                m_ign  = wr && !ok;
            end
            if (was_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_job == C_SEQ) begin
                        if (m_ptr == last_free(m_lvl)) begin m_seq = 0; m_wen = 0; end
                    end else m_wen = 0;
                end
            end
        end
    end

    task automatic cmp(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !finished) begin
            cmp("R11 busy bit",     status_o[0], (m_left > 0));
            cmp("R3 enable bit",    status_o[1], m_wen);
            cmp("R7 level bits",    status_o[3:2], m_lvl);
            cmp("R1 spare bits",    status_o[5:4], 0);
            cmp("R9 seq bit",       status_o[6], m_seq);
            cmp("R6 lock bit",      status_o[7], m_lock);
            cmp("R4 exec pulse",    exec_o, m_exec);
            cmp("R4 ignore pulse",  ignore_o, m_ign);
            cmp("R7 op address",    op_addr_o, m_addr);
            cmp("R9 seq mode port", seq_mode_o, m_seq);
        end
    end

    task automatic send(int o, int a = 0, int d = 0);
        cmd_valid = 1; cmd_op = o[3:0]; cmd_addr = a[AW-1:0]; cmd_data = d[7:0];
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic set_level(int d);
        send(C_ARM); send(C_STWR, 0, d);
    endtask

    initial begin : stim
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        model_on = 1;
        cmp("R2 reset status", status_o, 'h0C);
        cmp("R1 spare at reset", status_o[5:4], 0);

        send(C_OTHER);
        cmp("R12 other code no decision", exec_o | ignore_o, 0);
        send(C_PROG, 'h100);
        cmp("R4 program without enable", ignore_o, 1);
        send(C_WREN);
        cmp("R3 enable set", status_o[1], 1);
        send(C_PROG, 'h100);
        cmp("R7 level 11 refuses program", ignore_o, 1);

        send(C_STWR, 0, 0);
        cmp("R5 unarmed status write", ignore_o, 1);
        send(C_ARM); send(C_STRD); send(C_STWR, 0, 0);
        cmp("R5 arming voided by read", ignore_o, 1);
        set_level('h73);
        cmp("R5 masked status write", status_o, 'h02);

        send(C_PROG, 'h100);
        cmp("R10 program accepted", exec_o, 1);
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
        cmp("R10 program busy length", n, PC);
        cmp("R10 enable cleared on completion", status_o[1], 0);

        set_level('h04);
        send(C_WREN);
        send(C_PROG, 'h18000);
        cmp("R7 level 01 protects 18000h", ignore_o, 1);
        send(C_PROG, 'h17FFF);
        cmp("R7 level 01 allows 17FFFh", exec_o, 1);
        wait_idle();
        send(C_WREN);
        send(C_SECT, 'h18ABC);
        cmp("R7 protected sector refused", ignore_o, 1);
        send(C_SECT, 'h17ABC);
        cmp("R7 sector base address", op_addr_o, 'h17000);
        send(C_WREN);
        cmp("R11 enable refused while busy", ignore_o, 1);
        send(C_STRD);
        cmp("R11 status readable while busy", status_o[0], 1);
        n = 2;
        while (busy_o) begin n++; @(negedge clk); end
        cmp("R10 sector busy length", n, SC);
        send(C_WREN);
        send(C_BLK, 'h1FFFF);
        cmp("R7 protected block refused", ignore_o, 1);
        send(C_BLK, 'h0ABCD);
        cmp("R7 block base address", op_addr_o, 'h08000);
        wait_idle();

        send(C_WREN);
        send(C_CHIP);
        cmp("R8 chip erase refused at level 01", ignore_o, 1);
        set_level('h00);
        send(C_CHIP);
        cmp("R8 chip erase at level 00", exec_o, 1);
        wait_idle();
        cmp("R10 enable cleared after chip erase", status_o[1], 0);

        set_level('h08);
        send(C_WREN);
        send(C_SEQ, 'h0FFFE);
        cmp("R9 seq start address", op_addr_o, 'h0FFFE);
        cmp("R9 seq mode set", status_o[6], 1);
        wait_idle();
        send(C_PROG, 'h10);
        cmp("R9 plain program refused in seq mode", ignore_o, 1);
        send(C_SEQ, 'h12345);
        cmp("R9 seq next address", op_addr_o, 'h0FFFF);
        wait_idle();
        cmp("R9 seq ends at top free address", status_o[6:1] & 6'b100001, 0);

        send(C_WREN);
        send(C_SEQ, 'h00200);
        wait_idle();
        send(C_WRDI);
        cmp("R3 disable clears seq and enable", status_o[6:1] & 6'b100001, 0);

        wp_n = 0;
        set_level('h80);
        cmp("R6 lock set with pin low", status_o, 'h80);
        set_level('h0C);
        cmp("R6 locked write refused", ignore_o, 1);
        cmp("R6 status unchanged while locked", status_o, 'h80);
        wp_n = 1;
        set_level('h00);
        cmp("R6 pin high unlocks", status_o, 'h00);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule